// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block holds five alarm registers: seconds, minutes, hours, day of month and month. Each register is one byte. The top bit is an active-low match select and the lower seven bits hold a BCD value. On each one-cycle seconds strobe, every selected field is compared with the current BCD time value. A field whose select bit is 1 takes no part in the comparison.

If all selected fields agree on the strobe, a sticky alarm flag is set. Depending on which fields are selected, the alarm fires every second, once a minute, once an hour, once a day, or at one exact date and time. Software clears the flag by writing a 0 to its bit. An external alarm pin, active low by default, follows the flag while a pin-enable bit is set.

The time-keeping counters are outside this block and arrive as inputs. The block is configured through a simple write-only register port with the following map:

| Address | Contents |
|---|---|
| 0x08 | seconds alarm register |
| 0x09 | minutes alarm register |
| 0x0A | hours alarm register |
| 0x0B | day-of-month alarm register |
| 0x0C | month alarm register |
| 0x00, bit 6 | flag clear |
| 0x18, bit 6 | pin enable |

Top module: `cal_alarm_comparator`

## Requirements
- R1: After reset the flag is 0, the pin enable is 0 and the alarm pin is high. All five alarm registers reset to 0xFF, so every field is ignored and the first strobe sets the flag.
- R2: A field whose register bit 7 is 0 matches only when register bits 6:0 equal bits 6:0 of the time input. Bit 7 of the time input never affects the result.
- R3: When all five select bits are 1, every strobe sets the flag.
- R4: The comparison takes effect only in a cycle with the strobe high. A matching time without the strobe never sets the flag.
- R5: Once set, the flag stays at 1 through any number of strobes, matching or not, until software clears it.
- R6: A write to address 0x00 with data bit 6 equal to 0 clears the flag on the next clock. A write with bit 6 equal to 1 leaves the flag unchanged.
- R7: If a set event and a clear write happen in the same cycle, the flag ends up at 1.
- R8: The pin enable is bit 6 of a write to address 0x18. The alarm pin is low exactly when both the flag and the pin enable are 1. Otherwise it is high.
- R9: Writes to any address outside 0x00, 0x08 to 0x0C and 0x18 change neither the flag, the pin enable nor any alarm register.
- R10: Any mix of select bits is applied literally. For example, selecting only the hours field fires on every strobe whose hours value matches.
- R11: A write to an alarm register in the same cycle as a strobe does not affect that strobe. The comparison uses the value the register held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe; the time inputs are already updated when it is high |
| tm_sec | input | 8 | Current seconds, BCD |
| tm_min | input | 8 | Current minutes, BCD |
| tm_hour | input | 8 | Current hours, BCD |
| tm_date | input | 8 | Current day of month, BCD |
| tm_mon | input | 8 | Current month, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_pin | output | 1 | External alarm output, active low |

## Verification
The assertions assume that the strobe and the write port are sampled synchronously with no other timing restriction. In particular, a strobe may arrive in any cycle, including back-to-back cycles and the same cycle as a clear or an alarm-register write. The stimulus deliberately exercises that freedom. It draws time values from a narrow range so that matches are frequent, sets the top bit of the time inputs at random, and produces strobes, clears, pin-enable writes and writes to unmapped addresses in arbitrary overlap.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
   localparam int NUM_FIELDS = 5;

   typedef enum logic [2:0] {
      FLD_SEC  = 3'd0,
      FLD_MIN  = 3'd1,
      FLD_HOUR = 3'd2,
      FLD_DATE = 3'd3,
      FLD_MON  = 3'd4
   } field_e;
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
   import cal_alarm_pkg::*;
#(
   parameter int                DATA_W    = 8,
   parameter int                ADDR_W    = 5,
   parameter logic [ADDR_W-1:0] ALM_BASE  = 5'h08,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'h18,
   parameter int                PEN_BIT   = 6,
   parameter logic [DATA_W-1:0] ALM_RST   = '1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wr_en,
   input  logic [ADDR_W-1:0]                   wr_addr,
   input  logic [DATA_W-1:0]                   wr_data,
   output logic [NUM_FIELDS-1:0][DATA_W-1:0]   alm_q,
   output logic                                pin_en_q
);
   // One register per alarm field, each at its own decoded address.
   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
      localparam logic [ADDR_W-1:0] FIELD_ADDR = ADDR_W'(int'(ALM_BASE) + f);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            alm_q[f] <= ALM_RST;
         else if (wr_en && wr_addr == FIELD_ADDR)
            alm_q[f] <= wr_data;
      end
   end

   // Pin enable bit in the control register.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pin_en_q <= 1'b0;
      else if (wr_en && wr_addr == CTRL_ADDR)
         pin_en_q <= wr_data[PEN_BIT];
   end
endmodule

// File: rtl/alarm_field_match.sv
module alarm_field_match #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] alm,
   input  logic [DATA_W-1:0] now,
   output logic              hit
);
   localparam int VAL_W = DATA_W - 1;

   // The MSB of the time value carries no part of the BCD value.
   logic unused_now_msb;
   assign unused_now_msb = now[DATA_W-1];

   // A set MSB in the alarm register means the field is ignored and always hits.
   always_comb begin
      hit = alm[DATA_W-1] || (alm[VAL_W-1:0] == now[VAL_W-1:0]);
   end
endmodule

// File: rtl/alarm_flag_ctl.sv
module alarm_flag_ctl #(
   parameter int                DATA_W    = 8,
   parameter int                ADDR_W    = 5,
   parameter logic [ADDR_W-1:0] FLAG_ADDR = 5'h00,
   parameter int                FLAG_BIT  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic              all_hit,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_flag_bit,
   output logic              flag_q
);
   logic set_evt;
   logic clr_req;

   assign set_evt = sec_tick && all_hit;
   assign clr_req = wr_en && (wr_addr == FLAG_ADDR) && !wr_flag_bit;

   // A set event takes priority over a clear request in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (set_evt)
         flag_q <= 1'b1;
      else if (clr_req)
         flag_q <= 1'b0;
   end
endmodule

// File: rtl/cal_alarm_comparator.sv
module cal_alarm_comparator
   import cal_alarm_pkg::*;
#(
   parameter int                DATA_W         = 8,
   parameter int                ADDR_W         = 5,
   parameter logic [ADDR_W-1:0] FLAG_ADDR      = 5'h00,
   parameter logic [ADDR_W-1:0] CTRL_ADDR      = 5'h18,
   parameter logic [ADDR_W-1:0] ALM_BASE       = 5'h08,
   parameter int                FLAG_BIT       = 6,
   parameter int                PEN_BIT        = 6,
   parameter logic [DATA_W-1:0] ALM_RST        = '1,
   parameter bit                PIN_ACTIVE_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic [DATA_W-1:0] tm_sec,
   input  logic [DATA_W-1:0] tm_min,
   input  logic [DATA_W-1:0] tm_hour,
   input  logic [DATA_W-1:0] tm_date,
   input  logic [DATA_W-1:0] tm_mon,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              alarm_flag,
   output logic              alarm_pin
);
   localparam int ALM_LAST = int'(ALM_BASE) + NUM_FIELDS - 1;

   // Elaboration-time parameter checks
   if (DATA_W < 2)
      $error("DATA_W must leave room for a select bit and a value");
   if (FLAG_BIT >= DATA_W || PEN_BIT >= DATA_W)
      $error("flag or pin-enable bit position exceeds DATA_W");
   if (ALM_LAST >= (1 << ADDR_W))
      $error("alarm register window does not fit in the address space");
   if (FLAG_ADDR == CTRL_ADDR)
      $error("flag and control registers share an address");
   if (int'(FLAG_ADDR) >= int'(ALM_BASE) && int'(FLAG_ADDR) <= ALM_LAST)
      $error("flag register overlaps the alarm window");
   if (int'(CTRL_ADDR) >= int'(ALM_BASE) && int'(CTRL_ADDR) <= ALM_LAST)
      $error("control register overlaps the alarm window");

   logic [NUM_FIELDS-1:0][DATA_W-1:0] alm_q;
   logic [NUM_FIELDS-1:0][DATA_W-1:0] now_vec;
   logic [NUM_FIELDS-1:0]             field_hit;
   logic                              pin_en_q;
   logic                              flag_q;

   assign now_vec[int'(FLD_SEC)]  = tm_sec;
   assign now_vec[int'(FLD_MIN)]  = tm_min;
   assign now_vec[int'(FLD_HOUR)] = tm_hour;
   assign now_vec[int'(FLD_DATE)] = tm_date;
   assign now_vec[int'(FLD_MON)]  = tm_mon;

   alarm_regs #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .ALM_BASE (ALM_BASE),
      .CTRL_ADDR(CTRL_ADDR),
      .PEN_BIT  (PEN_BIT),
      .ALM_RST  (ALM_RST)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .alm_q   (alm_q),
      .pin_en_q(pin_en_q)
   );

   // One comparator per alarm field.
   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_cmp
      alarm_field_match #(.DATA_W(DATA_W)) u_match (
         .alm(alm_q[f]),
         .now(now_vec[f]),
         .hit(field_hit[f])
      );
   end

   alarm_flag_ctl #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .FLAG_ADDR(FLAG_ADDR),
      .FLAG_BIT (FLAG_BIT)
   ) u_flag (
      .clk        (clk),
      .rst_n      (rst_n),
      .sec_tick   (sec_tick),
      .all_hit    (&field_hit),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_flag_bit(wr_data[FLAG_BIT]),
      .flag_q     (flag_q)
   );

   assign alarm_flag = flag_q;

   // The pin polarity is chosen by a parameter.
   if (PIN_ACTIVE_LOW) begin : g_pin_low
      assign alarm_pin = !(flag_q && pin_en_q);
   end else begin : g_pin_high
      assign alarm_pin = flag_q && pin_en_q;
   end
endmodule

// File: rtl/cal_alarm_checker.sv
module cal_alarm_checker
   import cal_alarm_pkg::*;
#(
   parameter int                DATA_W         = 8,
   parameter int                ADDR_W         = 5,
   parameter logic [ADDR_W-1:0] FLAG_ADDR      = 5'h00,
   parameter int                FLAG_BIT       = 6,
   parameter bit                PIN_ACTIVE_LOW = 1'b1
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic                              sec_tick,
   input logic                              wr_en,
   input logic [ADDR_W-1:0]                 wr_addr,
   input logic [DATA_W-1:0]                 wr_data,
   input logic [NUM_FIELDS-1:0][DATA_W-1:0] alm,
   input logic                              pin_en,
   input logic                              alarm_flag,
   input logic                              alarm_pin
);
   logic                  clr_seen;
   logic [NUM_FIELDS-1:0] sel_bits;

   assign clr_seen = wr_en && (wr_addr == FLAG_ADDR) && !wr_data[FLAG_BIT];
   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_sel
      assign sel_bits[f] = alm[f][DATA_W-1];
   end

   p_no_rise_without_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !sec_tick |=> !$rose(alarm_flag));

   p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_flag && !clr_seen) |=> alarm_flag);

   p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_seen && !sec_tick) |=> !alarm_flag);

   p_every_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && (&sel_bits)) |=> alarm_flag);

   p_set_beats_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && (&sel_bits) && clr_seen) |=> alarm_flag);

   p_pin_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(alarm_flag && pin_en) |-> (alarm_pin == PIN_ACTIVE_LOW));

   p_pin_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_flag && pin_en) |-> (alarm_pin != PIN_ACTIVE_LOW));
endmodule

bind cal_alarm_comparator cal_alarm_checker #(
   .DATA_W        (DATA_W),
   .ADDR_W        (ADDR_W),
   .FLAG_ADDR     (FLAG_ADDR),
   .FLAG_BIT      (FLAG_BIT),
   .PIN_ACTIVE_LOW(PIN_ACTIVE_LOW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sec_tick  (sec_tick),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .alm       (alm_q),
   .pin_en    (pin_en_q),
   .alarm_flag(alarm_flag),
   .alarm_pin (alarm_pin)
);

// File: tb/cal_alarm_comparator_test.sv
`timescale 1ns/1ps
module cal_alarm_comparator_test;
   localparam logic [4:0] A_FLAG = 5'h00;
   localparam logic [4:0] A_CTRL = 5'h18;
   localparam logic [4:0] A_BASE = 5'h08;
   localparam int         MAX_CYC = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sec_tick = 1'b0;
   logic [7:0] tm_sec = '0, tm_min = '0, tm_hour = '0, tm_date = '0, tm_mon = '0;
   logic       wr_en = 1'b0;
   logic [4:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       alarm_flag, alarm_pin;

   int vectors = 0;
   int miscompares = 0;
   int cycles = 0;

   // Reference state kept by the bench
   logic [7:0] m_alm [5];
   bit         m_flag;
   bit         m_pen;

   always #4 clk = ~clk;

   cal_alarm_comparator uut (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
      .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour),
      .tm_date(tm_date), .tm_mon(tm_mon),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .alarm_flag(alarm_flag), .alarm_pin(alarm_pin)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > MAX_CYC) begin
         miscompares++;
         $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, MAX_CYC);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   function automatic bit fields_match(input logic [7:0] t [5]);
      bit ok = 1'b1;
      for (int i = 0; i < 5; i++)
         if (!m_alm[i][7] && (m_alm[i][6:0] != t[i][6:0])) ok = 1'b0;
      return ok;
   endfunction

   function automatic bit all_ignored();
      bit ok = 1'b1;
      for (int i = 0; i < 5; i++) if (!m_alm[i][7]) ok = 1'b0;
      return ok;
   endfunction

   task automatic check_out(input string tag);
      vectors++;
      if (alarm_flag !== m_flag) begin
         miscompares++;
         $display("FAIL %s: alarm_flag got %0b expected %0b", tag, alarm_flag, m_flag);
      end
      vectors++;
      if (alarm_pin !== !(m_flag && m_pen)) begin
         miscompares++;
         $display("FAIL %s/R8: alarm_pin got %0b expected %0b", tag, alarm_pin, !(m_flag && m_pen));
      end
   endtask

   // Called at a negative edge: drive the inputs, update the model, then check one cycle later.
   task automatic apply(input bit tk, input bit we, input logic [4:0] a, input logic [7:0] d,
                        input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                        input logic [7:0] dt, input logic [7:0] mo, input string tag);
      logic [7:0] t [5];
      bit set_e, clr_e;
      t[0] = s; t[1] = mi; t[2] = h; t[3] = dt; t[4] = mo;
      sec_tick = tk; wr_en = we; wr_addr = a; wr_data = d;
      tm_sec = s; tm_min = mi; tm_hour = h; tm_date = dt; tm_mon = mo;
      // The comparison uses the register values held before this cycle's write (R11).
      set_e = tk && fields_match(t);
      clr_e = we && (a == A_FLAG) && !d[6];
      if (set_e) m_flag = 1'b1;
      else if (clr_e) m_flag = 1'b0;
      if (we) begin
         if (a == A_CTRL) m_pen = d[6];
         for (int i = 0; i < 5; i++) if (a == A_BASE + 5'(i)) m_alm[i] = d;
      end
      @(posedge clk);
      @(negedge clk);
      sec_tick = 1'b0; wr_en = 1'b0;
      check_out(tag);
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d, input string tag);
      apply(1'b0, 1'b1, a, d, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, tag);
   endtask

   initial begin
      for (int i = 0; i < 5; i++) m_alm[i] = 8'hFF;
      m_flag = 1'b0;
      m_pen  = 1'b0;
      void'($urandom(32'h5EED_A1A2));
      repeat (3) @(negedge clk);
      check_out("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check_out("R1");

      // The default registers ignore every field, so the first strobe sets the flag.
      apply(1, 0, 0, 0, 8'h37, 8'h12, 8'h05, 8'h21, 8'h11, "R1");
      wr(A_CTRL, 8'h40, "R8");
      apply(1, 0, 0, 0, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, "R5");
      wr(A_FLAG, 8'h40, "R6");
      wr(5'h1F, 8'h00, "R9");
      wr(5'h0D, 8'h00, "R9");
      wr(A_FLAG, 8'hBF, "R6");
      apply(1, 0, 0, 0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, "R3");

      // Select only the seconds field.
      wr(A_FLAG, 8'h00, "R6");
      wr(A_BASE, 8'h15, "R2");
      apply(1, 0, 0, 0, 8'h16, 8'h00, 8'h00, 8'h00, 8'h00, "R2");
      apply(0, 0, 0, 0, 8'h15, 8'h00, 8'h00, 8'h00, 8'h00, "R4");
      apply(1, 0, 0, 0, 8'h95, 8'h00, 8'h00, 8'h00, 8'h00, "R2");
      apply(1, 0, 0, 0, 8'h44, 8'h00, 8'h00, 8'h00, 8'h00, "R5");

      // A matching strobe and a clear write in the same cycle.
      apply(1, 1, A_FLAG, 8'h00, 8'h15, 8'h00, 8'h00, 8'h00, 8'h00, "R7");
      wr(A_FLAG, 8'h00, "R6");

      // A strobe in the same cycle as an alarm write sees the old register value.
      apply(1, 1, A_BASE, 8'h20, 8'h20, 8'h00, 8'h00, 8'h00, 8'h00, "R11");
      apply(1, 0, 0, 0, 8'h20, 8'h00, 8'h00, 8'h00, 8'h00, "R11");
      wr(A_FLAG, 8'h00, "R6");

      // Select only the hours field.
      wr(A_BASE, 8'hFF, "R10");
      wr(A_BASE + 5'd2, 8'h07, "R10");
      apply(1, 0, 0, 0, 8'h33, 8'h44, 8'h06, 8'h01, 8'h01, "R10");
      apply(1, 0, 0, 0, 8'h33, 8'h44, 8'h07, 8'h01, 8'h01, "R10");
      wr(A_CTRL, 8'h00, "R8");

      // Constrained random mix of strobes and writes.
      for (int n = 0; n < 3000; n++) begin
         bit tk, we;
         logic [4:0] a;
         logic [7:0] d;
         logic [7:0] tv [5];
         logic [7:0] tt [5];
         string tag;
         int pick;
         tk = ($urandom % 2) == 0;
         we = ($urandom % 3) == 0;
         pick = $urandom % 9;
         if (pick < 5)       a = A_BASE + 5'(pick);
         else if (pick == 5) a = A_FLAG;
         else if (pick == 6) a = A_CTRL;
         else                a = 5'(5'h10 + ($urandom % 8));
         d = 8'($urandom);
         if (pick < 5) d = {($urandom % 3) != 0, 7'($urandom % 3)};
         for (int i = 0; i < 5; i++) tv[i] = {1'($urandom), 7'($urandom % 3)};
         for (int i = 0; i < 5; i++) tt[i] = tv[i];
         if (tk && we && a == A_FLAG && !d[6] && fields_match(tt)) tag = "R7";
         else if (tk && all_ignored()) tag = "R3";
         else if (tk) tag = "R10";
         else if (we && a == A_FLAG) tag = "R6";
         else if (we && pick > 6) tag = "R9";
         else tag = "R5";
         apply(tk, we, a, d, tv[0], tv[1], tv[2], tv[3], tv[4], tag);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule